// File: doc/BRIEF.md
# Quad-Channel Serial DAC Command Interface

This block is the digital front end of a four-channel 8-bit converter. A host shifts 12-bit command words in over a three-wire serial port (active-low select, serial clock, data in). Each word carries a 2-bit channel address, a 2-bit control field and an 8-bit data byte. The block keeps two register stages per channel: a staging (input) register and a live (output) register. The live values drive the converters. Commands can write one staging register, write one and then update all live registers, copy every staging register to the live stage, or broadcast one byte to every live register. Other commands enter or leave shutdown, set a general-purpose user output, and choose the serial clock edge on which the chain output changes.

All three serial lines, and the hardware load pin, pass through synchronizers into a single system clock domain. A word takes effect when select rises, and only if exactly twelve bits arrived while select was low. The bit that leaves the top of the shift register appears on the chain output, so several devices can share one select line in a daisy chain. A hardware load pin, held low, makes the live registers follow the staging registers. An active-low clear pin zeroes both register stages at once, without waiting for a clock.

Top module: `quad_dac_ctrl`

## Requirements
- R1: Bits are taken on rising serial-clock edges while select is low, first bit into the word's top position (order: address bit 1, address bit 0, control bit 1, control bit 0, data bit 7 down to data bit 0). The word is acted on when select rises, and only if exactly 12 bits were taken; 11 or 13 bits change nothing.
- R2: Control field 01 writes the data byte to the staging register picked by the address (00 = channel 0 in dac_out[7:0], 01 = channel 1, 10 = channel 2, 11 = channel 3); the live registers keep their values.
- R3: Control field 11 writes the addressed staging register and, in the same step, copies all four staging registers (including the new byte) into the live registers.
- R4: Address+control 0000 is a no-operation: no register or flag changes.
- R5: Address+control 0100 copies every staging register into its live register and clears shutdown.
- R6: Address+control 1000 writes the data byte into all four live registers, leaves the staging registers alone and clears shutdown.
- R7: Address+control 1100 sets shutdown only when pde is high at the time the word is acted on; with pde low, shutdown is unchanged.
- R8: Address+control 0010 drives upo low; 0110 drives upo high.
- R9: Address+control 1010 selects falling-edge chain output (mode 0) and 1110 selects rising-edge chain output (mode 1); both also copy all staging registers to the live registers.
- R10: dout carries the top bit of the shift register. In mode 0 it is loaded when select falls and on each falling serial-clock edge. In mode 1 it is loaded on each rising serial-clock edge with the bit about to leave.
- R11: While load_n is low, the live registers follow the staging registers.
- R12: clr_n low zeroes all staging and live registers at once, without waiting for a clock edge.
- R13: After reset, all registers are zero, shutdown and upo are low, dout is low and mode 0 is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial lines are oversampled with it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data in |
| load_n | input | 1 | Hardware load, active low: live registers follow staging registers |
| clr_n | input | 1 | Asynchronous active-low clear of all channel registers |
| pde | input | 1 | Permits the shutdown command when high |
| dout | output | 1 | Daisy-chain serial output |
| dac_out | output | NCH*DW (32) | Live register values, channel 0 in the low byte |
| shutdown | output | 1 | Software shutdown flag |
| upo | output | 1 | User-programmable logic output |

## Verification
The bench builds the block with its defaults: four channels of eight bits and two synchronizer stages. With these values every address and control combination in the 4-bit command space is reachable, and each live byte can be checked on its own lane of the 32-bit output. A serial half-period of four system clocks is longer than the three-cycle synchronizer and edge-detect path. This lets the bench sample dout between serial edges and tell the two chain-output modes apart by a single bit position.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;

  // Control field values that carry a channel write
  localparam logic [1:0] CTL_STAGE      = 2'b01;
  localparam logic [1:0] CTL_STAGE_UPD  = 2'b11;

  // Full address+control codes for the global commands
  localparam logic [3:0] OP_NOP        = 4'b0000;
  localparam logic [3:0] OP_COPY_ALL   = 4'b0100;
  localparam logic [3:0] OP_BROADCAST  = 4'b1000;
  localparam logic [3:0] OP_SLEEP      = 4'b1100;
  localparam logic [3:0] OP_USER_LO    = 4'b0010;
  localparam logic [3:0] OP_USER_HI    = 4'b0110;
  localparam logic [3:0] OP_EDGE_FALL  = 4'b1010;
  localparam logic [3:0] OP_EDGE_RISE  = 4'b1110;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_mode_e;

endpackage

// File: rtl/quad_dac_sync.sv
module quad_dac_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= {stg_q[STAGES-2:0], d};
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/quad_dac_rst_sync.sv
module quad_dac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/quad_dac_serial_rx.sv
module quad_dac_serial_rx #(
  parameter int WORD = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n_s,
  input  logic            sclk_s,
  input  logic            din_s,
  input  logic            edge_rise,
  output logic [WORD-1:0] word_o,
  output logic            commit_o,
  output logic            dout_o
);
  localparam int CW = $clog2(WORD + 2);

  logic            sclk_q, cs_q;
  logic [WORD-1:0] sr_q, sr_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            dout_q, dout_d;
  logic            sclk_rise, sclk_fall, cs_fall, cs_rise;

  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;
  assign cs_fall   = ~cs_n_s & cs_q;
  assign cs_rise   = cs_n_s & ~cs_q;

  always_comb begin
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    dout_d = dout_q;
    if (cs_fall) begin
      cnt_d = '0;
      if (!edge_rise) dout_d = sr_q[WORD-1];
    end else if (!cs_n_s && sclk_rise) begin
      sr_d = {sr_q[WORD-2:0], din_s};
      if (cnt_q <= CW'(WORD)) cnt_d = cnt_q + CW'(1);
      if (edge_rise) dout_d = sr_q[WORD-1];
    end else if (!cs_n_s && sclk_fall && !edge_rise) begin
      dout_d = sr_q[WORD-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      sr_q   <= '0;
      cnt_q  <= '0;
      dout_q <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      cs_q   <= cs_n_s;
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      dout_q <= dout_d;
    end
  end

  assign word_o   = sr_q;
  assign commit_o = cs_rise && (cnt_q == CW'(WORD));
  assign dout_o   = dout_q;
endmodule

// File: rtl/quad_dac_regfile.sv
module quad_dac_regfile
  import quad_dac_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 8,
  parameter int AW  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arst_n,
  input  logic                 commit,
  input  logic [AW+2+DW-1:0]   word,
  input  logic                 pde,
  input  logic                 hold_n,
  output logic [NCH*DW-1:0]    dac_flat,
  output logic                 shutdown,
  output logic                 upo,
  output logic                 edge_rise
);
  logic [AW-1:0]           addr;
  logic [1:0]              ctl;
  logic [DW-1:0]           data;
  logic [NCH-1:0][DW-1:0]  in_q, in_d, out_q, out_d;
  logic                    out_set, data_en;
  logic                    shdn_q, shdn_d, upo_q, upo_d;
  edge_mode_e              mode_q, mode_d;

  assign addr    = word[AW+2+DW-1 -: AW];
  assign ctl     = word[DW+1:DW];
  assign data    = word[DW-1:0];
  assign data_en = commit | ~hold_n;

  always_comb begin
    in_d    = in_q;
    out_d   = out_q;
    out_set = 1'b0;
    shdn_d  = shdn_q;
    upo_d   = upo_q;
    mode_d  = mode_q;
    if (commit) begin
      unique case (ctl)
        CTL_STAGE: in_d[addr] = data;
        CTL_STAGE_UPD: begin
          in_d[addr] = data;
          out_d      = in_d;
          out_set    = 1'b1;
        end
        default: begin
          unique case ({addr, ctl})
            OP_COPY_ALL: begin
              out_d   = in_q;
              out_set = 1'b1;
              shdn_d  = 1'b0;
            end
            OP_BROADCAST: begin
              out_d   = {NCH{data}};
              out_set = 1'b1;
              shdn_d  = 1'b0;
            end
            OP_SLEEP:     if (pde) shdn_d = 1'b1;
            OP_USER_LO:   upo_d = 1'b0;
            OP_USER_HI:   upo_d = 1'b1;
            OP_EDGE_FALL: begin
              mode_d  = EDGE_FALL;
              out_d   = in_q;
              out_set = 1'b1;
            end
            OP_EDGE_RISE: begin
              mode_d  = EDGE_RISE;
              out_d   = in_q;
              out_set = 1'b1;
            end
            default: ;
          endcase
        end
      endcase
    end
    if (!out_set && !hold_n) out_d = in_d;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [DW-1:0] in_r, out_r;
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
        in_r  <= '0;
        out_r <= '0;
      end else if (data_en) begin
        in_r  <= in_d[ch];
        out_r <= out_d[ch];
      end
    end
    assign in_q[ch]  = in_r;
    assign out_q[ch] = out_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shdn_q <= 1'b0;
      upo_q  <= 1'b0;
      mode_q <= EDGE_FALL;
    end else if (commit) begin
      shdn_q <= shdn_d;
      upo_q  <= upo_d;
      mode_q <= mode_d;
    end
  end

  assign dac_flat  = out_q;
  assign shutdown  = shdn_q;
  assign upo       = upo_q;
  assign edge_rise = (mode_q == EDGE_RISE);
endmodule

// File: rtl/quad_dac_ctrl.sv
module quad_dac_ctrl #(
  parameter int NCH         = 4,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic              load_n,
  input  logic              clr_n,
  input  logic              pde,
  output logic              dout,
  output logic [NCH*DW-1:0] dac_out,
  output logic              shutdown,
  output logic              upo
);
  localparam int AW   = $clog2(NCH);
  localparam int WORD = AW + 2 + DW;

  logic            sys_rst_n, data_rst_n;
  logic            cs_n_s, sclk_s, din_s, hold_n;
  logic            commit, edge_rise;
  logic [WORD-1:0] word;

  quad_dac_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sys (
    .clk(clk), .arst_n(rst_n), .rst_n_o(sys_rst_n)
  );

  quad_dac_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_data (
    .clk(clk), .arst_n(rst_n & clr_n), .rst_n_o(data_rst_n)
  );

  quad_dac_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_pin_sync (
    .clk(clk), .rst_n(sys_rst_n),
    .d({cs_n, sclk, din, load_n}),
    .q({cs_n_s, sclk_s, din_s, hold_n})
  );

  quad_dac_serial_rx #(.WORD(WORD)) u_rx (
    .clk(clk), .rst_n(sys_rst_n),
    .cs_n_s(cs_n_s), .sclk_s(sclk_s), .din_s(din_s),
    .edge_rise(edge_rise),
    .word_o(word), .commit_o(commit), .dout_o(dout)
  );

  quad_dac_regfile #(.NCH(NCH), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(sys_rst_n), .arst_n(data_rst_n),
    .commit(commit), .word(word), .pde(pde), .hold_n(hold_n),
    .dac_flat(dac_out), .shutdown(shutdown), .upo(upo),
    .edge_rise(edge_rise)
  );
endmodule

// File: rtl/quad_dac_ctrl_chk.sv
module quad_dac_ctrl_chk #(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input logic              clk,
  input logic              sys_rst_n,
  input logic              data_rst_n,
  input logic              commit,
  input logic              cs_n_s,
  input logic              hold_n,
  input logic              pde,
  input logic [NCH*DW-1:0] dac_out,
  input logic              shutdown,
  input logic              upo
);
  // R1: a word is acted on only once select is back high
  p_commit_cs_high_r1: assert property (@(posedge clk) disable iff (!sys_rst_n)
    commit |-> cs_n_s);

  // R1: one action per select rise
  p_commit_single_r1: assert property (@(posedge clk) disable iff (!sys_rst_n)
    commit |=> !commit);

  // R2: live values move only on a command, the load pin or a clear
  p_live_hold_r2: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (dac_out != $past(dac_out)) |->
      ($past(commit) || !$past(hold_n) || !data_rst_n || !$past(data_rst_n)));

  // R7: shutdown is entered only by a command issued with pde high
  p_sleep_pde_r7: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $rose(shutdown) |-> ($past(pde) && $past(commit)));

  // R8: the user output moves only on a command
  p_user_on_cmd_r8: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (upo != $past(upo)) |-> $past(commit));

  // R12: live values are zero while the clear is held
  p_clear_zero_r12: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !data_rst_n |-> (dac_out == '0));
endmodule

bind quad_dac_ctrl quad_dac_ctrl_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .sys_rst_n(sys_rst_n), .data_rst_n(data_rst_n),
  .commit(commit), .cs_n_s(cs_n_s), .hold_n(hold_n), .pde(pde),
  .dac_out(dac_out), .shutdown(shutdown), .upo(upo)
);

// File: tb/sim_quad_dac_ctrl.sv
`timescale 1ns/1ps
module sim_quad_dac_ctrl;
  localparam int HP = 4;
  localparam int NV = 16;

  logic        clk, rst_n, cs_n, sclk, din, load_n, clr_n, pde;
  logic        dout, shutdown, upo;
  logic [31:0] dac_out;
  int          checks = 0;
  int          errors = 0;

  quad_dac_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .load_n(load_n), .clr_n(clr_n), .pde(pde), .dout(dout),
    .dac_out(dac_out), .shutdown(shutdown), .upo(upo)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {word, pde, expected dac_out, expected shutdown, expected upo}
  localparam logic [46:0] VEC [NV] = '{
    {12'h111, 1'b0, 32'h00000000, 1'b0, 1'b0},  // R2 stage ch0
    {12'h522, 1'b0, 32'h00000000, 1'b0, 1'b0},  // R2 stage ch1
    {12'hB33, 1'b0, 32'h00332211, 1'b0, 1'b0},  // R3 stage ch2 + update
    {12'hD44, 1'b0, 32'h00332211, 1'b0, 1'b0},  // R2 stage ch3
    {12'h0FF, 1'b0, 32'h00332211, 1'b0, 1'b0},  // R4 no-op
    {12'h4EE, 1'b0, 32'h44332211, 1'b0, 1'b0},  // R5 copy all
    {12'hC00, 1'b1, 32'h44332211, 1'b1, 1'b0},  // R7 sleep, pde high
    {12'h85A, 1'b1, 32'h5A5A5A5A, 1'b0, 1'b0},  // R6 broadcast
    {12'hC00, 1'b0, 32'h5A5A5A5A, 1'b0, 1'b0},  // R7 sleep blocked
    {12'h600, 1'b0, 32'h5A5A5A5A, 1'b0, 1'b1},  // R8 user high
    {12'hE00, 1'b0, 32'h44332211, 1'b0, 1'b1},  // R9 rising mode + update
    {12'h200, 1'b0, 32'h44332211, 1'b0, 1'b0},  // R8 user low
    {12'hC00, 1'b1, 32'h44332211, 1'b1, 1'b0},  // R7 sleep
    {12'h400, 1'b0, 32'h44332211, 1'b0, 1'b0},  // R5 copy clears sleep
    {12'hA00, 1'b0, 32'h44332211, 1'b0, 1'b0},  // R9 falling mode
    {12'h399, 1'b0, 32'h44332299, 1'b0, 1'b0}   // R3 stage ch0 + update
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    wait_clk(HP);
  endtask

  task automatic bit_out(input logic b);
    din = b;
    wait_clk(HP);
    sclk = 1'b1;
    wait_clk(HP);
    sclk = 1'b0;
    wait_clk(HP);
  endtask

  task automatic cs_hi();
    cs_n = 1'b1;
    wait_clk(10);
  endtask

  task automatic send(input logic [15:0] w, input int nbits);
    cs_lo();
    for (int i = nbits - 1; i >= 0; i--) bit_out(w[i]);
    cs_hi();
  endtask

  initial begin
    wait_clk(100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; din = 1'b0;
    load_n = 1'b1; clr_n = 1'b1; pde = 1'b0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(10);

    // R13 reset state
    chk("R13 dac_out", dac_out, 32'h0);
    chk("R13 shutdown", {31'b0, shutdown}, 32'h0);
    chk("R13 upo", {31'b0, upo}, 32'h0);
    chk("R13 dout", {31'b0, dout}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      pde = VEC[v][34];
      send({4'h0, VEC[v][46:35]}, 12);
      chk($sformatf("table %0d dac_out", v), dac_out, VEC[v][33:2]);
      chk($sformatf("table %0d shutdown", v), {31'b0, shutdown}, {31'b0, VEC[v][1]});
      chk($sformatf("table %0d upo", v), {31'b0, upo}, {31'b0, VEC[v][0]});
    end
    pde = 1'b0;

    // R1 eleven bits of a broadcast word are ignored
    send(16'h045A, 11);
    chk("R1 short word", dac_out, 32'h44332299);
    // R1 thirteen bits ending in a broadcast word are ignored
    send(16'h185A, 13);
    chk("R1 long word", dac_out, 32'h44332299);

    // R2 staging write leaves live values; R11 load pin copies it through
    send(16'h0177, 12);
    chk("R2 live unchanged", dac_out, 32'h44332299);
    load_n = 1'b0;
    wait_clk(10);
    chk("R11 live follows staging", dac_out, 32'h44332277);
    load_n = 1'b1;
    wait_clk(10);

    // R10 mode 0: dout on select fall and on falling serial edges
    send(16'h0D81, 12);
    cs_lo();
    chk("R10 mode0 after select fall", {31'b0, dout}, 32'h1);
    bit_out(1'b0);
    chk("R10 mode0 after fall 1", {31'b0, dout}, 32'h1);
    bit_out(1'b0);
    chk("R10 mode0 after fall 2", {31'b0, dout}, 32'h0);
    for (int i = 2; i < 12; i++) bit_out(1'b0);
    cs_hi();

    // R9 rising mode; R10 dout loaded on rising edges with the leaving bit
    send(16'h0E00, 12);
    cs_lo();
    bit_out(1'b0);
    bit_out(1'b0);
    bit_out(1'b0);
    chk("R10 mode1 after bit 3", {31'b0, dout}, 32'h1);
    bit_out(1'b0);
    chk("R10 mode1 after bit 4", {31'b0, dout}, 32'h0);
    for (int i = 4; i < 12; i++) bit_out(1'b0);
    cs_hi();
    send(16'h0A00, 12);

    // R12 clear acts without a clock and empties the staging stage too
    @(negedge clk);
    #2 clr_n = 1'b0;
    #1 chk("R12 immediate zero", dac_out, 32'h0);
    wait_clk(4);
    clr_n = 1'b1;
    wait_clk(10);
    send(16'h0400, 12);
    chk("R12 staging cleared", dac_out, 32'h0);

    report();
  end
endmodule